// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Reload Down-Timer

This block is a 16-bit down-counter paired with a 16-bit reload latch. It is built for an 8-bit host that can move only one byte per bus cycle. Each qualified count pulse lowers the counter by one. The pulse source is either an internal divider that fires once every `DIV` clock cycles (16 by default) or a single-cycle external strobe. When the counter is already at zero, the next pulse does not wrap it. Instead the counter takes the latch value and sets a sticky interrupt flag, which stays set until software clears it.

The two data bytes are transferred atomically in a fixed order. On writes the low byte goes first and is held in a staging byte. The later high-byte write then moves all 16 bits in one cycle. On reads the high byte goes first and the low byte of that same instant is captured in a read buffer. A separate control write sets three things: a halt bit, the pulse source, and a latch-only bit that keeps data writes away from the live counter. The same control write can also clear the interrupt flag.

Top module: `reload_downtimer`

## Requirements
- R1: Synchronous reset sets the counter and the latch to 0xFFFF, clears the interrupt flag, the staging byte and the read buffer, and leaves the timer halted with internal source and latch-only cleared.
- R2: While not halted, each qualified count pulse lowers a nonzero counter by exactly one.
- R3: A pulse that arrives while the counter is 0x0000 loads the latch value into the counter and sets `irq`. Reaching zero alone does not set `irq`.
- R4: `irq` stays at 1 until a control write (`cs`&`ctl_wr`) with `wdata[3]`=1 clears it. If an underflow and a clear fall in the same cycle, `irq` is set.
- R5: A data read with `addr`=1 returns counter bits 15:8 and captures bits 7:0 in that cycle. A following read with `addr`=0 returns the captured byte, even if the counter has changed in between.
- R6: A data write with `addr`=0 only stages the byte. A data write with `addr`=1 moves {new byte, staged byte} to the latch in one cycle.
- R7: Control bit `wdata[1]` is latch-only. At 0, a high-byte write loads both the latch and the counter. At 1, it loads only the latch, and the counter takes the new value at its next underflow.
- R8: Control bit `wdata[0]` halts counting while set. Data writes and reads still work while halted.
- R9: With control bit `wdata[2]`=0, the pulse source is the internal divider, giving exactly one pulse every `DIV` clock cycles.
- R10: A counter load from a high-byte write in the same cycle as a count pulse wins: the counter holds the written value and does not underflow.
- R11: With the internal source selected, `ext_pulse` has no effect. With `wdata[2]`=1, each cycle with `ext_pulse` high is one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for all accesses |
| wr | input | 1 | Data byte write strobe |
| rd | input | 1 | Data byte read strobe |
| ctl_wr | input | 1 | Control write strobe (bit0 halt, bit1 latch-only, bit2 external source, bit3 clear irq) |
| addr | input | 1 | Byte select: 1 high, 0 low |
| wdata | input | 8 | Write data |
| ext_pulse | input | 1 | External count strobe, one pulse per high cycle |
| rdata | output | 8 | Read data, valid while `cs`&`rd` |
| irq | output | 1 | Sticky underflow interrupt request |

## Verification
The counting function is driven in several ways. One is a run of single external strobes across a nonzero span, which shows that the counter decrements and does not reload. Another is a run through zero, which separates reaching zero from the underflow pulse and its reload. A third is two 32-cycle windows on the internal divider, one with `ext_pulse` held high, which shows the source select and the divide ratio. The remaining cases each hit one corner: a strobe placed between the two halves of a read proves that the snapshot is coherent. A write and a strobe in the same cycle prove write priority. An underflow in the same cycle as a flag clear proves that set wins. A latch-only write, watched up to the next reload, shows that it reaches the counter only through the latch.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t WORD_ONES = '1;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } bsel_e;

    // control byte bit positions
    localparam int unsigned CB_HALT  = 0;
    localparam int unsigned CB_LONLY = 1;
    localparam int unsigned CB_EXT   = 2;
    localparam int unsigned CB_CLR   = 3;

    typedef struct packed {
        logic ext_src;
        logic latch_only;
        logic halt;
    } mode_t;

    localparam mode_t MODE_RESET = '{ext_src: 1'b0, latch_only: 1'b0, halt: 1'b1};

    typedef struct packed {
        logic  valid;
        logic  to_cnt;
        word_t value;
    } wload_t;

    function automatic mode_t decode_mode(byte_t d);
        mode_t m;
        m.halt       = d[CB_HALT];
        m.latch_only = d[CB_LONLY];
        m.ext_src    = d[CB_EXT];
        return m;
    endfunction

    function automatic word_t join_bytes(byte_t hi, byte_t lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/rdt_prescaler.sv
module rdt_prescaler #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_src,
    input  logic ext_pulse,
    input  logic halt,
    output logic pulse
);
    logic div_tick;

    generate
        if (DIV <= 1) begin : g_nodiv
            assign div_tick = 1'b1;
        end else begin : g_div
            localparam int unsigned PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] div_q;
            assign div_tick = (div_q == LAST);
            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q <= '0;
                end else if (div_tick) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    endgenerate

    assign pulse = (ext_src ? ext_pulse : div_tick) & ~halt;

endmodule

// File: rtl/rdt_busif.sv
module rdt_busif
    import rdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs,
    input  logic   wr,
    input  logic   rd,
    input  logic   ctl_wr,
    input  logic   addr,
    input  byte_t  wdata,
    input  word_t  cnt,
    output byte_t  rdata,
    output wload_t wload,
    output mode_t  mode,
    output logic   irq_clr
);
    byte_t stage_lo_q;
    byte_t rbuf_q;
    mode_t mode_q;

    logic wr_lo, wr_hi, rd_hi, ctl_we;
    assign wr_lo  = cs & wr & (bsel_e'(addr) == SEL_LO);
    assign wr_hi  = cs & wr & (bsel_e'(addr) == SEL_HI);
    assign rd_hi  = cs & rd & (bsel_e'(addr) == SEL_HI);
    assign ctl_we = cs & ctl_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo_q <= '0;
            rbuf_q     <= '0;
            mode_q     <= MODE_RESET;
        end else begin
            if (wr_lo)  stage_lo_q <= wdata;
            if (rd_hi)  rbuf_q     <= cnt[BYTE_W-1:0];
            if (ctl_we) mode_q     <= decode_mode(wdata);
        end
    end

    always_comb begin
        wload.valid  = wr_hi;
        wload.to_cnt = ~mode_q.latch_only;
        wload.value  = join_bytes(wdata, stage_lo_q);
    end

    always_comb begin
        rdata = '0;
        if (cs & rd) begin
            rdata = (bsel_e'(addr) == SEL_HI) ? cnt[WORD_W-1:BYTE_W] : rbuf_q;
        end
    end

    assign mode    = mode_q;
    assign irq_clr = ctl_we & wdata[CB_CLR];

endmodule

// File: rtl/rdt_core.sv
module rdt_core
    import rdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pulse,
    input  wload_t wload,
    input  logic   irq_clr,
    output word_t  cnt,
    output word_t  latch,
    output logic   underflow,
    output logic   irq
);
    word_t cnt_q, latch_q;
    logic  irq_q;
    logic  cnt_wr;

    assign cnt_wr    = wload.valid & wload.to_cnt;
    assign underflow = pulse & ~cnt_wr & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= WORD_ONES;
            latch_q <= WORD_ONES;
            irq_q   <= 1'b0;
        end else begin
            if (wload.valid) latch_q <= wload.value;

            if (cnt_wr) begin
                cnt_q <= wload.value;
            end else if (underflow) begin
                cnt_q <= latch_q;
            end else if (pulse) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (underflow) begin
                irq_q <= 1'b1;
            end else if (irq_clr) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign cnt   = cnt_q;
    assign latch = latch_q;
    assign irq   = irq_q;

endmodule

// File: rtl/reload_downtimer.sv
module reload_downtimer #(
    parameter int unsigned DIV = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs,
    input  logic                       wr,
    input  logic                       rd,
    input  logic                       ctl_wr,
    input  logic                       addr,
    input  logic [rdt_pkg::BYTE_W-1:0] wdata,
    input  logic                       ext_pulse,
    output logic [rdt_pkg::BYTE_W-1:0] rdata,
    output logic                       irq
);
    import rdt_pkg::*;

    word_t  cnt_w, latch_w;
    wload_t wl;
    mode_t  mode_w;
    logic   clr_w, pulse_w, uf_w;
    logic   cnt_load;
    word_t  load_val;

    assign cnt_load = wl.valid & wl.to_cnt;
    assign load_val = wl.value;

    rdt_busif u_bus (
        .clk    (clk),
        .rst    (rst),
        .cs     (cs),
        .wr     (wr),
        .rd     (rd),
        .ctl_wr (ctl_wr),
        .addr   (addr),
        .wdata  (wdata),
        .cnt    (cnt_w),
        .rdata  (rdata),
        .wload  (wl),
        .mode   (mode_w),
        .irq_clr(clr_w)
    );

    rdt_prescaler #(.DIV(DIV)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .ext_src  (mode_w.ext_src),
        .ext_pulse(ext_pulse),
        .halt     (mode_w.halt),
        .pulse    (pulse_w)
    );

    rdt_core u_core (
        .clk      (clk),
        .rst      (rst),
        .pulse    (pulse_w),
        .wload    (wl),
        .irq_clr  (clr_w),
        .cnt      (cnt_w),
        .latch    (latch_w),
        .underflow(uf_w),
        .irq      (irq)
    );

endmodule

// File: rtl/reload_downtimer_chk.sv
module reload_downtimer_chk (
    input logic        clk,
    input logic        rst,
    input logic        pulse,
    input logic        halt,
    input logic        cnt_load,
    input logic [15:0] load_val,
    input logic [15:0] cnt,
    input logic [15:0] latch,
    input logic        irq,
    input logic        irq_clr
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == 16'hFFFF && latch == 16'hFFFF && !irq));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse && !cnt_load && cnt != 16'h0000) |=> (cnt == $past(cnt) - 16'd1));

    assert_reload_on_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (pulse && !cnt_load && cnt == 16'h0000) |=> (cnt == $past(latch) && irq));

    assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    assert_frozen_when_halted_R8: assert property (@(posedge clk) disable iff (rst)
        (halt && !cnt_load) |=> $stable(cnt));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> (cnt == $past(load_val)));

endmodule

bind reload_downtimer reload_downtimer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pulse   (pulse_w),
    .halt    (mode_w.halt),
    .cnt_load(cnt_load),
    .load_val(load_val),
    .cnt     (cnt_w),
    .latch   (latch_w),
    .irq     (irq),
    .irq_clr (clr_w)
);

// File: tb/sim_reload_downtimer.sv
`timescale 1ns/1ps
module sim_reload_downtimer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, ctl_wr = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       ext_pulse = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    reload_downtimer #(.DIV(16)) u0 (
        .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .ctl_wr(ctl_wr),
        .addr(addr), .wdata(wdata), .ext_pulse(ext_pulse),
        .rdata(rdata), .irq(irq)
    );

    // monitor: compares read bytes against the scoreboard queue
    always begin
        @(negedge clk);
        #5;
        if (cs && rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic check_val(input logic [15:0] act, input logic [15:0] exp, input string t);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic idle();
        cs = 0; wr = 0; rd = 0; ctl_wr = 0; addr = 0; wdata = 8'h00;
    endtask

    task automatic wr_byte(input logic a, input logic [7:0] d);
        cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic wr_word(input logic [15:0] v);
        wr_byte(1'b0, v[7:0]);
        wr_byte(1'b1, v[15:8]);
    endtask

    task automatic set_mode(input logic halt, input logic lonly, input logic ext, input logic clr);
        cs = 1; ctl_wr = 1; wdata = {4'b0000, clr, ext, lonly, halt};
        @(negedge clk);
        idle();
    endtask

    task automatic rd_byte(input logic a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        cs = 1; rd = 1; addr = a;
        @(negedge clk);
        idle();
    endtask

    task automatic expect_word(input logic [15:0] v, input string t);
        rd_byte(1'b1, v[15:8], t);
        rd_byte(1'b0, v[7:0], t);
    endtask

    task automatic raw_word(output logic [15:0] v);
        cs = 1; rd = 1; addr = 1;
        #5 v[15:8] = rdata;
        @(negedge clk);
        addr = 0;
        #5 v[7:0] = rdata;
        @(negedge clk);
        idle();
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pulse = 1;
            @(negedge clk);
        end
        ext_pulse = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] a, b, c;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state, halted even with internal divider running
        check_val({15'd0, irq}, 16'd0, "R1 irq");
        repeat (40) @(negedge clk);
        expect_word(16'hFFFF, "R1 counter");

        // R6/R7: full word write with latch-only cleared
        set_mode(1'b1, 1'b0, 1'b1, 1'b0);
        wr_word(16'h1234);
        expect_word(16'h1234, "R7 write both");
        wr_byte(1'b0, 8'hAA);
        wr_byte(1'b1, 8'h56);
        expect_word(16'h56AA, "R6 staged transfer");

        // R2: external pulses decrement
        set_mode(1'b0, 1'b0, 1'b1, 1'b0);
        ext_pulses(5);
        expect_word(16'h56A5, "R2 decrement");

        // R8: halted ignores pulses, access still works
        set_mode(1'b1, 1'b0, 1'b1, 1'b0);
        ext_pulses(4);
        expect_word(16'h56A5, "R8 frozen");
        wr_word(16'h0003);
        expect_word(16'h0003, "R8 write while halted");

        // R3: reaching zero, then underflow reloads
        set_mode(1'b0, 1'b0, 1'b1, 1'b0);
        ext_pulses(3);
        expect_word(16'h0000, "R3 at zero");
        check_val({15'd0, irq}, 16'd0, "R3 no irq at zero");
        ext_pulses(1);
        expect_word(16'h0003, "R3 reload");
        check_val({15'd0, irq}, 16'd1, "R3 irq set");

        // R4: sticky, clear, set wins over clear
        ext_pulses(2);
        check_val({15'd0, irq}, 16'd1, "R4 sticky");
        set_mode(1'b0, 1'b0, 1'b1, 1'b1);
        check_val({15'd0, irq}, 16'd0, "R4 cleared");
        ext_pulses(1);
        cs = 1; ctl_wr = 1; wdata = 8'b0000_1100; ext_pulse = 1;
        @(negedge clk);
        idle(); ext_pulse = 0;
        check_val({15'd0, irq}, 16'd1, "R4 set wins");
        expect_word(16'h0003, "R4 reload");
        set_mode(1'b0, 1'b0, 1'b1, 1'b1);
        check_val({15'd0, irq}, 16'd0, "R4 cleared again");

        // R5: coherent snapshot across a count between byte reads
        wr_word(16'h0100);
        rd_byte(1'b1, 8'h01, "R5 high");
        ext_pulses(1);
        rd_byte(1'b0, 8'h00, "R5 buffered low");
        expect_word(16'h00FF, "R5 next snapshot");

        // R7: latch-only write reaches counter at underflow
        wr_word(16'h0001);
        set_mode(1'b0, 1'b1, 1'b1, 1'b0);
        wr_word(16'h0050);
        expect_word(16'h0001, "R7 counter untouched");
        ext_pulses(1);
        expect_word(16'h0000, "R7 zero");
        ext_pulses(1);
        expect_word(16'h0050, "R7 new latch loaded");
        set_mode(1'b0, 1'b0, 1'b1, 1'b1);

        // R10: write and pulse in the same cycle
        wr_byte(1'b0, 8'h22);
        cs = 1; wr = 1; addr = 1; wdata = 8'h11; ext_pulse = 1;
        @(negedge clk);
        idle(); ext_pulse = 0;
        expect_word(16'h1122, "R10 write wins");

        // R9/R11: internal divider, 32-cycle windows
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        raw_word(a);
        repeat (30) @(negedge clk);
        raw_word(b);
        check_val(a - b, 16'd2, "R9 divide by 16");
        ext_pulse = 1;
        repeat (30) @(negedge clk);
        ext_pulse = 0;
        raw_word(c);
        check_val(b - c, 16'd2, "R11 ext ignored");
        check_val({15'd0, irq}, 16'd0, "R11 no irq");

        // R8: halt with internal source
        set_mode(1'b1, 1'b0, 1'b0, 1'b0);
        raw_word(a);
        repeat (40) @(negedge clk);
        raw_word(b);
        check_val(b, a, "R8 halted internal");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule